// File: doc/BRIEF.md
# Page-Table-Walking Address Translator

This block sits between an 8-bit CPU with a 16-bit address bus and a memory with a 20-bit address bus and an 8-bit data bus. It keeps no translation table of its own. Every CPU access starts a walk with three memory accesses. The first two read the two bytes of a page table entry from ordinary memory. The third performs the CPU's own read or write at the translated physical address. Pages are 256 bytes. The virtual page number is CPU address bits 15:8, and the physical page number is 12 bits wide.

Two table base registers are kept, one for user mode and one for kernel mode. The CPU mode input is sampled when a request is accepted, and it picks which base is used. Before the third access, the entry's permission flags are checked against the access type. A violation suppresses that access and raises a fault instead. The CPU is stalled through a ready output for the whole walk. Software loads the base registers through a small register port, which takes effect only while the sequencer is idle.

Top module: `mmu_walk_top`

## Requirements
- R1: After reset, `cpu_ready_o`, `fault_o`, `mem_en_o` and `mem_we_o` are low, and both base registers hold zero.
- R2: In the cycle after a request is sampled while idle, the block performs a read (`mem_en_o`=1, `mem_we_o`=0). The address is {base[10:0], cpu_addr[15:8], 1'b0}. The byte read becomes physical page bits 7:0.
- R3: In the next cycle the block reads at {base[10:0], cpu_addr[15:8], 1'b1}. Bits 3:0 of that byte become physical page bits 11:8, and bits 7:4 become flags 3:0.
- R4: In the third cycle the block accesses {ppn[11:0], cpu_addr[7:0]}. `mem_we_o` is high only in this cycle and only for a CPU write, and `mem_wdata_o` carries the CPU write data.
- R5: `cpu_ready_o` is low during the walk. It is high for exactly one cycle, the fourth after the request is sampled. In that cycle `cpu_rdata_o` holds the byte read in the third access.
- R6: If flag 0 (present) is clear, the third access is suppressed (`mem_en_o` stays low), and `fault_o` is high together with the ready pulse.
- R7: A CPU write (`cpu_we_i`=1) to a page whose flag 1 (writable) is clear faults in the same way, and memory is not written.
- R8: An opcode fetch (`cpu_fetch_i`=1) from a page whose flag 2 (executable) is clear faults. A plain read never faults on flags 1 or 2, and flag 3 has no effect.
- R9: `cpu_kernel_i`=1 selects the kernel base and 0 selects the user base. The mode is sampled together with the request.
- R10: A base write (`cfg_we_i`, where `cfg_kernel_i`=1 selects the kernel base and 0 the user base) takes effect only when the sequencer is idle. A write made during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request |
| cpu_addr_i | input | 16 | CPU virtual address |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_fetch_i | input | 1 | CPU access is an opcode fetch |
| cpu_kernel_i | input | 1 | CPU mode, 1 = kernel |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |
| cpu_ready_o | output | 1 | One-cycle completion pulse, low while stalled |
| fault_o | output | 1 | Permission or presence fault, valid with ready |
| cfg_we_i | input | 1 | Base register write strobe |
| cfg_kernel_i | input | 1 | Base register select, 1 = kernel |
| cfg_base_i | input | 11 | Base register write value |
| mem_addr_o | output | 20 | Physical memory address |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the cycle of the access |

## Verification
The walk is driven with plain reads, writes and opcode fetches in both modes, using distinct base values and page numbers. These show that the base, the virtual page number and both halves of the entry land in the right address bits. A write followed by a read of the same location confirms that the third access really reaches memory. The flag patterns cover each of present, writable and executable clear, plus a set flag 3. This separates the three fault causes from one another and from accesses that must pass. A base write issued in the middle of a walk, followed by a second access, shows whether that write was dropped.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_ACC,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/mmu_base_regs.sv
module mmu_base_regs #(
  parameter int unsigned BASE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              wr_en_i,
  input  logic              wr_kernel_i,
  input  logic [BASE_W-1:0] wr_data_i,
  input  logic              mode_i,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0] base_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                               base_q[g] <= '0;
      else if (wr_en_i && idle_i && (wr_kernel_i == 1'(g)))      base_q[g] <= wr_data_i;
    end
  end

  assign base_o = base_q[mode_i];

  // R10
  base_frozen_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ($stable(base_q[0]) && $stable(base_q[1])));
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check (
  input  logic [2:0] flags_i,
  input  logic       we_i,
  input  logic       fetch_i,
  output logic       fault_o
);
  logic present, writable, execable;
  assign present  = flags_i[0];
  assign writable = flags_i[1];
  assign execable = flags_i[2];
  assign fault_o  = !present || (we_i && !writable) || (fetch_i && !execable);
endmodule

// File: rtl/mmu_walk_fsm.sv
module mmu_walk_fsm
  import mmu_walk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     fault_i,
  output walk_st_e st_o,
  output logic     ready_o,
  output logic     fault_o
);
  walk_st_e st_q, st_d;
  logic     fault_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_LO;
      ST_LO:   st_d = ST_HI;
      ST_HI:   st_d = ST_ACC;
      ST_ACC:  st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= (st_q == ST_ACC) && fault_i;
    end
  end

  assign st_o    = st_q;
  assign ready_o = (st_q == ST_DONE);
  assign fault_o = fault_q;

  // R5
  ready_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R6
  fault_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ready_o);
endmodule

// File: rtl/mmu_walk_top.sv
module mmu_walk_top
  import mmu_walk_pkg::*;
#(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned PA_W   = 20,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned D_W    = 8,
  localparam int unsigned VPN_W    = VA_W - PAGE_W,
  localparam int unsigned PPN_W    = PA_W - PAGE_W,
  localparam int unsigned BASE_W   = PA_W - VPN_W - 1,
  localparam int unsigned PPN_HI_W = PPN_W - D_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [VA_W-1:0]   cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic              cpu_fetch_i,
  input  logic              cpu_kernel_i,
  input  logic [D_W-1:0]    cpu_wdata_i,
  output logic [D_W-1:0]    cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              fault_o,
  input  logic              cfg_we_i,
  input  logic              cfg_kernel_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [D_W-1:0]    mem_wdata_o,
  input  logic [D_W-1:0]    mem_rdata_i
);
  walk_st_e          st;
  logic              idle, accept, fault_now;
  logic [VA_W-1:0]   va_q;
  logic              we_q, fetch_q, mode_q;
  logic [D_W-1:0]    wdata_q, rdata_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [2:0]        flags_q;
  logic [BASE_W-1:0] base;

  assign idle   = (st == ST_IDLE);
  assign accept = idle && cpu_req_i;

  mmu_walk_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (cpu_req_i),
    .fault_i (fault_now),
    .st_o    (st),
    .ready_o (cpu_ready_o),
    .fault_o (fault_o)
  );

  mmu_base_regs #(.BASE_W(BASE_W)) i_base (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle),
    .wr_en_i     (cfg_we_i),
    .wr_kernel_i (cfg_kernel_i),
    .wr_data_i   (cfg_base_i),
    .mode_i      (mode_q),
    .base_o      (base)
  );

  mmu_perm_check i_perm (
    .flags_i (flags_q),
    .we_i    (we_q),
    .fetch_i (fetch_q),
    .fault_o (fault_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= '0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      mode_q  <= 1'b1;  // kernel after reset
      wdata_q <= '0;
    end else if (accept) begin
      va_q    <= cpu_addr_i;
      we_q    <= cpu_we_i;
      fetch_q <= cpu_fetch_i;
      mode_q  <= cpu_kernel_i;
      wdata_q <= cpu_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppn_q   <= '0;
      flags_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st)
        ST_LO: ppn_q[D_W-1:0] <= mem_rdata_i;
        ST_HI: begin
          ppn_q[PPN_W-1:D_W] <= mem_rdata_i[PPN_HI_W-1:0];
          flags_q            <= mem_rdata_i[PPN_HI_W+2:PPN_HI_W];
        end
        ST_ACC: if (!we_q && !fault_now) rdata_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_LO:   mem_addr_o = {base, va_q[VA_W-1:PAGE_W], 1'b0};
      ST_HI:   mem_addr_o = {base, va_q[VA_W-1:PAGE_W], 1'b1};
      ST_ACC:  mem_addr_o = {ppn_q, va_q[PAGE_W-1:0]};
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_en_o    = (st == ST_LO) || (st == ST_HI) || ((st == ST_ACC) && !fault_now);
  assign mem_we_o    = (st == ST_ACC) && we_q && !fault_now;
  assign mem_wdata_o = wdata_q;
  assign cpu_rdata_o = rdata_q;

  // R4
  write_third_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(st == ST_HI));
  // R2
  walk_starts_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LO) |-> ($past(cpu_req_i) && !mem_we_o));
  // R6
  fault_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(!mem_en_o));
endmodule

// File: tb/test_mmu_walk_top.sv
module test_mmu_walk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, fetch = 1'b0, kmode = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready, fault;
  logic        cfg_we = 1'b0, cfg_k = 1'b0;
  logic [10:0] cfg_base = '0;
  logic [19:0] mem_addr;
  logic        mem_en, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  mmu_walk_top i_mmu_walk_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_we_i(we), .cpu_fetch_i(fetch),
    .cpu_kernel_i(kmode), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .cpu_ready_o(ready), .fault_o(fault),
    .cfg_we_i(cfg_we), .cfg_kernel_i(cfg_k), .cfg_base_i(cfg_base),
    .mem_addr_o(mem_addr), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem_q [logic [19:0]];
  logic [7:0] ref_q [logic [19:0]];

  function automatic logic [7:0] dflt(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  always_comb mem_rdata = mem_q.exists(mem_addr) ? mem_q[mem_addr] : dflt(mem_addr);
  always @(posedge clk) if (mem_we) mem_q[mem_addr] = mem_wdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [19:0] lo, hi, ph;
    logic        wr, flt;
    logic [7:0]  wd, rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [10:0] ubase = '0, kbase = '0;

  task automatic set_pte(logic [10:0] b, logic [7:0] vpn, logic [11:0] ppn, logic [3:0] fl);
    mem_q[{b, vpn, 1'b0}] = ppn[7:0];
    mem_q[{b, vpn, 1'b1}] = {fl, ppn[11:8]};
    ref_q[{b, vpn, 1'b0}] = ppn[7:0];
    ref_q[{b, vpn, 1'b1}] = {fl, ppn[11:8]};
  endtask

  task automatic set_base(logic k, logic [10:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_k = k; cfg_base = v;
    @(negedge clk);
    cfg_we = 0;
    if (k) kbase = v; else ubase = v;
  endtask

  function automatic logic [7:0] rd_ref(logic [19:0] a);
    return ref_q.exists(a) ? ref_q[a] : dflt(a);
  endfunction

  task automatic access(logic [15:0] a, logic w, logic f, logic k, logic [7:0] d,
                        string tag, bit poke = 0);
    exp_t e;
    logic [10:0] b;
    logic [7:0]  lo_b, hi_b;
    logic [3:0]  fl;
    int n;
    b    = k ? kbase : ubase;
    e.lo = {b, a[15:8], 1'b0};
    e.hi = {b, a[15:8], 1'b1};
    lo_b = rd_ref(e.lo);
    hi_b = rd_ref(e.hi);
    fl   = hi_b[7:4];
    e.ph = {hi_b[3:0], lo_b, a[7:0]};
    e.flt = !fl[0] || (w && !fl[1]) || (f && !fl[2]);
    e.wr = w; e.wd = d; e.tag = tag;
    e.rd = rd_ref(e.ph);
    if (!e.flt && w) ref_q[e.ph] = d;
    sb.push_back(e);
    @(negedge clk);
    req = 1; addr = a; we = w; fetch = f; kmode = k; wdata = d;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin cfg_we = 1; cfg_k = k; cfg_base = 11'h7FF; end
      else cfg_we = 0;
      if (ready || n >= 8) break;
      check(!ready, "R5 ready low during walk", ready, 0);
    end
    check(n == 4, "R5 ready cycle", n, 4);
    req = 0;
    cfg_we = 0;
  endtask

  // monitor: log memory accesses, compare on each ready pulse
  logic [19:0] la [3];
  logic        lw [3];
  logic [7:0]  lwd[3];
  int          nacc = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_en) begin
        if (nacc < 3) begin
          la[nacc] = mem_addr; lw[nacc] = mem_we; lwd[nacc] = mem_wdata;
        end
        nacc++;
      end
      if (rst_n && ready) begin
        exp_t e;
        if (sb.size() == 0) check(0, "R5 unexpected ready", 1, 0);
        else begin
          e = sb.pop_front();
          check(nacc == (e.flt ? 2 : 3), {e.tag, " R6 access count"}, nacc, e.flt ? 2 : 3);
          check(la[0] == e.lo && !lw[0], {e.tag, " R2 low entry read"}, la[0], e.lo);
          check(la[1] == e.hi && !lw[1], {e.tag, " R3 high entry read"}, la[1], e.hi);
          check(fault == e.flt, {e.tag, " fault"}, fault, e.flt);
          if (!e.flt && nacc == 3) begin
            check(la[2] == e.ph, {e.tag, " R4 phys addr"}, la[2], e.ph);
            check(lw[2] == e.wr, {e.tag, " R4 write enable"}, lw[2], e.wr);
            if (e.wr) check(lwd[2] == e.wd, {e.tag, " R4 write data"}, lwd[2], e.wd);
            else check(rdata == e.rd, {e.tag, " R5 read data"}, rdata, e.rd);
          end
        end
        nacc = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ready && !fault && !mem_en && !mem_we, "R1 outputs in reset",
          {ready, fault, mem_en, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!ready && !fault && !mem_en && !mem_we, "R1 outputs after reset",
          {ready, fault, mem_en, mem_we}, 0);

    // R1: bases are zero after reset
    set_pte(11'h000, 8'h12, 12'hABC, 4'hF);
    access(16'h1234, 0, 0, 1, 8'h00, "R1 kernel base zero");
    access(16'h12C0, 0, 0, 0, 8'h00, "R1 user base zero");

    set_base(0, 11'h123);
    set_base(1, 11'h456);
    set_pte(11'h456, 8'h34, 12'h9A5, 4'h3);
    set_pte(11'h123, 8'h34, 12'h1F0, 4'h7);
    // R4 write then read back
    access(16'h3410, 1, 0, 1, 8'h99, "R4 kernel write");
    access(16'h3410, 0, 0, 1, 8'h00, "R4 kernel readback");
    // R9 same vaddr, other mode
    access(16'h3410, 0, 0, 0, 8'h00, "R9 user mode");
    access(16'h3477, 1, 0, 0, 8'h3C, "R9 user write");

    // R8 fetch from non-exec page faults, plain read does not
    access(16'h3401, 0, 1, 1, 8'h00, "R8 fetch no-exec");
    access(16'h3402, 0, 0, 1, 8'h00, "R8 read no-exec");
    set_pte(11'h123, 8'h50, 12'h0C3, 4'h5);
    access(16'h5010, 0, 1, 0, 8'h00, "R8 fetch exec ok");
    // R7 write to read-only page
    access(16'h5011, 1, 0, 0, 8'hEE, "R7 write read-only");
    access(16'h5011, 0, 0, 0, 8'h00, "R7 readback untouched");
    // R6 not present
    set_pte(11'h456, 8'h60, 12'h777, 4'hE);
    access(16'h6000, 0, 0, 1, 8'h00, "R6 not present");
    access(16'h6001, 1, 1, 1, 8'h55, "R6 not present write");
    // R8 flag 3 ignored
    set_pte(11'h456, 8'h70, 12'h321, 4'h7);
    set_pte(11'h456, 8'h71, 12'h322, 4'hF);
    access(16'h70AA, 1, 0, 1, 8'h11, "R8 flag3 clear");
    access(16'h71AA, 1, 0, 1, 8'h22, "R8 flag3 set");

    // R10 base write during walk is dropped
    access(16'h3420, 0, 0, 1, 8'h00, "R10 poke walk", 1);
    access(16'h3421, 0, 0, 1, 8'h00, "R10 after poke");
    set_base(1, 11'h7FF);
    set_pte(11'h7FF, 8'h34, 12'hFED, 4'h1);
    access(16'h3422, 0, 0, 1, 8'h00, "R10 idle write applies");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5 all walks completed", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule